// File: doc/BRIEF.md
# Multicycle Instruction Sequencer

This block is the control unit of a small processor whose datapath shares one memory port and one ALU between all steps of an instruction. It is a Moore machine: a 4-bit state register advances once per clock, and every datapath control line is a function of the current state alone. The 6-bit opcode held in the instruction register only picks which path the machine takes through its ten states. The path, and so the cycle count, depends on the instruction class: jumps and branches take 3 cycles, stores and register-to-register operations take 4, and loads take 5.

A separate combinational gate merges the unconditional and conditional PC-write requests with the ALU zero flag into one PC load enable. The block has no streaming data path. Its opcode and zero inputs and all of its control outputs are plain level signals, so there is no valid/ready handshake and no back-pressure. The current state number is brought out on `phase` so that the datapath, or a debugger, can see which step is running.

Top module: `mc_seq_ctrl`

## Requirements
- R1: While `rst` is high at a rising edge, the next state is 0 (fetch), so `phase` reads 0 after that edge.
- R2: In state 0, `pc_wr`, `mem_rd` and `ir_ld` are 1, `addr_sel_data`=0, `alu_a_sel`=0, `alu_b_sel`=01 (constant 4), `alu_mode`=00 (add) and `pc_src`=00 (ALU result). The next state is always 1.
- R3: In state 1, `alu_a_sel`=0, `alu_b_sel`=11 (shifted offset) and `alu_mode`=00. The next state depends on the opcode: 000000 (register op) goes to 6, 000010 (jump) to 9, 000100 (branch-if-equal) to 8, and 100011 (load) or 101011 (store) to 2.
- R4: In state 2, `alu_a_sel`=1, `alu_b_sel`=10 (sign-extended offset) and `alu_mode`=00. The next state is 3 for a load opcode, 5 for a store opcode and 0 for anything else.
- R5: In state 3, `mem_rd`=1 and `addr_sel_data`=1, and the next state is 4. In state 4, `rf_wr`=1, `rf_dst_rd`=0 and `wb_sel_mem`=1.
- R6: In state 5, `mem_wr`=1 and `addr_sel_data`=1.
- R7: In state 6, `alu_a_sel`=1, `alu_b_sel`=00 (register B) and `alu_mode`=10 (function field), and the next state is 7. In state 7, `rf_wr`=1, `rf_dst_rd`=1 and `wb_sel_mem`=0.
- R8: In state 8, `alu_a_sel`=1, `alu_b_sel`=00, `alu_mode`=01 (subtract), `pc_wr_cond`=1 and `pc_src`=01 (saved target).
- R9: In state 9, `pc_wr`=1 and `pc_src`=10 (jump target).
- R10: States 4, 5, 7, 8 and 9 always go to state 0. An instruction therefore takes, counting from its fetch cycle, 5 cycles for a load, 4 for a store or register op, and 3 for a branch or jump.
- R11: `pc_en` equals `pc_wr` OR (`pc_wr_cond` AND `alu_zero`) in the same cycle.
- R12: An opcode outside the five listed values, decoded in state 1, sends the machine back to state 0, so the instruction takes 2 cycles.
- R13: Every control output that R2 to R9 do not name for a state is 0 in that state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 6 | Opcode field of the instruction register |
| alu_zero | input | 1 | ALU result-is-zero flag |
| pc_wr | output | 1 | Unconditional PC write request |
| pc_wr_cond | output | 1 | PC write request qualified by zero |
| pc_en | output | 1 | Combined PC load enable |
| addr_sel_data | output | 1 | Memory address from saved ALU result (1) or PC (0) |
| mem_rd | output | 1 | Memory read |
| mem_wr | output | 1 | Memory write |
| ir_ld | output | 1 | Instruction register load |
| wb_sel_mem | output | 1 | Register write data from memory data (1) or ALU result (0) |
| pc_src | output | 2 | PC source select |
| alu_mode | output | 2 | ALU operation class |
| alu_a_sel | output | 1 | ALU A input: register A (1) or PC (0) |
| alu_b_sel | output | 2 | ALU B input select |
| rf_wr | output | 1 | Register file write |
| rf_dst_rd | output | 1 | Destination from rd field (1) or rt field (0) |
| phase | output | 4 | Current state number |

## Verification
The control lines and `phase` are registered through the single state register. They change one clock edge after the opcode they depend on is sampled, and hold for the whole of the following cycle. `pc_en` is combinational and follows `alu_zero` within the same cycle. The bench drives `opcode` and `alu_zero` on the falling edge, steps its own state model across the rising edge, and compares every output on the next falling edge, one full cycle per state. Instruction lengths are measured from the `phase` returns to 0 that the design itself produces.

// File: rtl/mc_seq_pkg.sv
package mc_seq_pkg;
  localparam int OP_W    = 6;
  localparam int STATE_W = 4;

  localparam logic [OP_W-1:0] OP_REG   = 6'b000000;
  localparam logic [OP_W-1:0] OP_JUMP  = 6'b000010;
  localparam logic [OP_W-1:0] OP_BEQ   = 6'b000100;
  localparam logic [OP_W-1:0] OP_LOAD  = 6'b100011;
  localparam logic [OP_W-1:0] OP_STORE = 6'b101011;

  typedef enum logic [STATE_W-1:0] {
    ST_FETCH  = 4'd0,
    ST_DECODE = 4'd1,
    ST_ADDR   = 4'd2,
    ST_MEMRD  = 4'd3,
    ST_LDWB   = 4'd4,
    ST_MEMWR  = 4'd5,
    ST_REXE   = 4'd6,
    ST_RDONE  = 4'd7,
    ST_BRANCH = 4'd8,
    ST_JUMP   = 4'd9
  } st_e;

  typedef struct packed {
    logic       pc_wr;
    logic       pc_wr_cond;
    logic       addr_sel_data;
    logic       mem_rd;
    logic       mem_wr;
    logic       ir_ld;
    logic       wb_sel_mem;
    logic [1:0] pc_src;
    logic [1:0] alu_mode;
    logic       alu_a_sel;
    logic [1:0] alu_b_sel;
    logic       rf_wr;
    logic       rf_dst_rd;
  } ctrl_t;

  function automatic logic op_known(input logic [OP_W-1:0] op);
    return (op == OP_REG) || (op == OP_JUMP) || (op == OP_BEQ) ||
           (op == OP_LOAD) || (op == OP_STORE);
  endfunction
endpackage

// File: rtl/mc_next_state.sv
module mc_next_state
  import mc_seq_pkg::*;
(
  input  st_e             cur,
  input  logic [OP_W-1:0] opcode,
  output st_e             nxt
);
  always_comb begin
    nxt = ST_FETCH;
    case (cur)
      ST_FETCH:  nxt = ST_DECODE;
      ST_DECODE: begin
        case (opcode)
          OP_REG:   nxt = ST_REXE;
          OP_JUMP:  nxt = ST_JUMP;
          OP_BEQ:   nxt = ST_BRANCH;
          OP_LOAD,
          OP_STORE: nxt = ST_ADDR;
          default:  nxt = ST_FETCH;  // unknown opcode: restart
        endcase
      end
      ST_ADDR: begin
        if (opcode == OP_LOAD)       nxt = ST_MEMRD;
        else if (opcode == OP_STORE) nxt = ST_MEMWR;
        else                         nxt = ST_FETCH;
      end
      ST_MEMRD:  nxt = ST_LDWB;
      ST_REXE:   nxt = ST_RDONE;
      default:   nxt = ST_FETCH;     // 4, 5, 7, 8, 9 and unused codes
    endcase
  end
endmodule

// File: rtl/mc_ctrl_decode.sv
module mc_ctrl_decode
  import mc_seq_pkg::*;
(
  input  st_e   cur,
  output ctrl_t ctl
);
  always_comb begin
    ctl = '0;  // every line not named below stays inactive
    case (cur)
      ST_FETCH: begin
        ctl.mem_rd    = 1'b1;
        ctl.ir_ld     = 1'b1;
        ctl.pc_wr     = 1'b1;
        ctl.alu_b_sel = 2'b01;
      end
      ST_DECODE: ctl.alu_b_sel = 2'b11;
      ST_ADDR: begin
        ctl.alu_a_sel = 1'b1;
        ctl.alu_b_sel = 2'b10;
      end
      ST_MEMRD: begin
        ctl.mem_rd        = 1'b1;
        ctl.addr_sel_data = 1'b1;
      end
      ST_LDWB: begin
        ctl.rf_wr      = 1'b1;
        ctl.wb_sel_mem = 1'b1;
      end
      ST_MEMWR: begin
        ctl.mem_wr        = 1'b1;
        ctl.addr_sel_data = 1'b1;
      end
      ST_REXE: begin
        ctl.alu_a_sel = 1'b1;
        ctl.alu_mode  = 2'b10;
      end
      ST_RDONE: begin
        ctl.rf_wr     = 1'b1;
        ctl.rf_dst_rd = 1'b1;
      end
      ST_BRANCH: begin
        ctl.alu_a_sel  = 1'b1;
        ctl.alu_mode   = 2'b01;
        ctl.pc_wr_cond = 1'b1;
        ctl.pc_src     = 2'b01;
      end
      ST_JUMP: begin
        ctl.pc_wr  = 1'b1;
        ctl.pc_src = 2'b10;
      end
      default: ctl = '0;
    endcase
  end
endmodule

// File: rtl/mc_pc_gate.sv
module mc_pc_gate (
  input  logic wr,
  input  logic wr_cond,
  input  logic zero,
  output logic en
);
  assign en = wr | (wr_cond & zero);
endmodule

// File: rtl/mc_seq_ctrl.sv
module mc_seq_ctrl
  import mc_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic [5:0]  opcode,
  input  logic        alu_zero,
  output logic        pc_wr,
  output logic        pc_wr_cond,
  output logic        pc_en,
  output logic        addr_sel_data,
  output logic        mem_rd,
  output logic        mem_wr,
  output logic        ir_ld,
  output logic        wb_sel_mem,
  output logic [1:0]  pc_src,
  output logic [1:0]  alu_mode,
  output logic        alu_a_sel,
  output logic [1:0]  alu_b_sel,
  output logic        rf_wr,
  output logic        rf_dst_rd,
  output logic [3:0]  phase
);
  st_e   state, state_nxt;
  ctrl_t ctl;

  mc_next_state u_next (.cur(state), .opcode(opcode), .nxt(state_nxt));
  mc_ctrl_decode u_dec (.cur(state), .ctl(ctl));

  always_ff @(posedge clk) begin
    if (rst) state <= ST_FETCH;
    else     state <= state_nxt;
  end

  assign pc_wr         = ctl.pc_wr;
  assign pc_wr_cond    = ctl.pc_wr_cond;
  assign addr_sel_data = ctl.addr_sel_data;
  assign mem_rd        = ctl.mem_rd;
  assign mem_wr        = ctl.mem_wr;
  assign ir_ld         = ctl.ir_ld;
  assign wb_sel_mem    = ctl.wb_sel_mem;
  assign pc_src        = ctl.pc_src;
  assign alu_mode      = ctl.alu_mode;
  assign alu_a_sel     = ctl.alu_a_sel;
  assign alu_b_sel     = ctl.alu_b_sel;
  assign rf_wr         = ctl.rf_wr;
  assign rf_dst_rd     = ctl.rf_dst_rd;
  assign phase         = state;

  mc_pc_gate u_gate (.wr(ctl.pc_wr), .wr_cond(ctl.pc_wr_cond), .zero(alu_zero), .en(pc_en));

  AST_RESET_FETCH: assert property (@(posedge clk) rst |=> (state == ST_FETCH)); // R1
  AST_TERM_RETURN: assert property (@(posedge clk) disable iff (rst)
    (state inside {ST_LDWB, ST_MEMWR, ST_RDONE, ST_BRANCH, ST_JUMP}) |=> (state == ST_FETCH)); // R10
  AST_LOAD_SEQ: assert property (@(posedge clk) disable iff (rst)
    (state == ST_MEMRD) |=> (state == ST_LDWB)); // R5
  AST_REG_SEQ: assert property (@(posedge clk) disable iff (rst)
    (state == ST_REXE) |=> (state == ST_RDONE)); // R7
  AST_BAD_OPCODE: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DECODE && !op_known(opcode)) |=> (state == ST_FETCH)); // R12
  AST_PC_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!pc_wr && !pc_wr_cond) |-> !pc_en); // R11
  AST_ONE_STORE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({mem_wr, rf_wr, ir_ld})); // R13
endmodule

// File: tb/mc_seq_ctrl_tb.sv
module mc_seq_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [5:0] opcode = 6'd0;
  logic alu_zero = 1'b0;
  logic pc_wr, pc_wr_cond, pc_en, addr_sel_data, mem_rd, mem_wr, ir_ld, wb_sel_mem;
  logic [1:0] pc_src, alu_mode, alu_b_sel;
  logic alu_a_sel, rf_wr, rf_dst_rd;
  logic [3:0] phase;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  mc_seq_ctrl dut_i (
    .clk(clk), .rst(rst), .opcode(opcode), .alu_zero(alu_zero),
    .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond), .pc_en(pc_en),
    .addr_sel_data(addr_sel_data), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .ir_ld(ir_ld), .wb_sel_mem(wb_sel_mem), .pc_src(pc_src),
    .alu_mode(alu_mode), .alu_a_sel(alu_a_sel), .alu_b_sel(alu_b_sel),
    .rf_wr(rf_wr), .rf_dst_rd(rf_dst_rd), .phase(phase)
  );

  // next state per R2, R3, R4, R5, R7, R10, R12
  function automatic logic [3:0] model_next(input logic [3:0] s, input logic [5:0] op);
    case (s)
      4'd0: return 4'd1;
      4'd1: case (op)
              6'b000000: return 4'd6;
              6'b000010: return 4'd9;
              6'b000100: return 4'd8;
              6'b100011, 6'b101011: return 4'd2;
              default: return 4'd0;
            endcase
      4'd2: return (op == 6'b100011) ? 4'd3 : (op == 6'b101011) ? 4'd5 : 4'd0;
      4'd3: return 4'd4;
      4'd6: return 4'd7;
      default: return 4'd0;
    endcase
  endfunction

  // {pc_wr,pc_wr_cond,addr_sel_data,mem_rd,mem_wr,ir_ld,wb_sel_mem,
  //  pc_src,alu_mode,alu_a_sel,alu_b_sel,rf_wr,rf_dst_rd}; zero elsewhere per R13
  function automatic logic [15:0] model_ctl(input logic [3:0] s);
    case (s)
      4'd0: return {1'b1,1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,2'b00,2'b00,1'b0,2'b01,1'b0,1'b0};
      4'd1: return {7'b0,2'b00,2'b00,1'b0,2'b11,2'b00};
      4'd2: return {7'b0,2'b00,2'b00,1'b1,2'b10,2'b00};
      4'd3: return {1'b0,1'b0,1'b1,1'b1,3'b000,4'b0,1'b0,2'b00,2'b00};
      4'd4: return {6'b0,1'b1,4'b0,1'b0,2'b00,1'b1,1'b0};
      4'd5: return {1'b0,1'b0,1'b1,1'b0,1'b1,2'b00,4'b0,1'b0,2'b00,2'b00};
      4'd6: return {7'b0,2'b00,2'b10,1'b1,2'b00,2'b00};
      4'd7: return {7'b0,2'b00,2'b00,1'b0,2'b00,1'b1,1'b1};
      4'd8: return {1'b0,1'b1,5'b0,2'b01,2'b01,1'b1,2'b00,2'b00};
      4'd9: return {1'b1,6'b0,2'b10,2'b00,1'b0,2'b00,2'b00};
      default: return 16'h0;
    endcase
  endfunction

  function automatic string req_of(input logic [3:0] s);
    case (s)
      4'd0: return "R2/R13";
      4'd1: return "R3/R13";
      4'd2: return "R4/R13";
      4'd3, 4'd4: return "R5/R13";
      4'd5: return "R6/R13";
      4'd6, 4'd7: return "R7/R13";
      4'd8: return "R8/R13";
      4'd9: return "R9/R13";
      default: return "R13";
    endcase
  endfunction

  // cycles per instruction, R10 and R12
  function automatic int model_len(input logic [5:0] op);
    case (op)
      6'b100011: return 5;
      6'b101011, 6'b000000: return 4;
      6'b000100, 6'b000010: return 3;
      default: return 2;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [5:0] pick_op(input int idx);
    logic [5:0] list [6] = '{6'b100011, 6'b101011, 6'b000000, 6'b000100, 6'b000010, 6'b111111};
    if (idx < 6) return list[idx];
    case ($urandom % 7)
      0: return 6'b100011;
      1: return 6'b101011;
      2: return 6'b000000;
      3: return 6'b000100;
      4: return 6'b000010;
      default: return 6'($urandom);
    endcase
  endfunction

  initial begin
    logic [3:0] exp_st;
    logic [15:0] act_ctl;
    int run_len;
    int instr;
    int seed_dummy;
    seed_dummy = $urandom(32'd1357);
    exp_st = 4'd0;
    run_len = 0;
    instr = 0;
    repeat (3) @(negedge clk);
    check(phase == 4'd0, "R1", phase, 0);
    check(ir_ld && mem_rd && !rf_wr && !mem_wr, "R1", {ir_ld, mem_rd, rf_wr, mem_wr}, 4'b1100);
    opcode = pick_op(instr);
    instr++;
    rst = 1'b0;
    exp_st = 4'd1;
    run_len = 1;
    while (instr < 400) begin
      @(negedge clk);
      act_ctl = {pc_wr, pc_wr_cond, addr_sel_data, mem_rd, mem_wr, ir_ld, wb_sel_mem,
                 pc_src, alu_mode, alu_a_sel, alu_b_sel, rf_wr, rf_dst_rd};
      check(phase == exp_st, "R3/R4 state", phase, exp_st);
      check(act_ctl == model_ctl(exp_st), req_of(exp_st), act_ctl, model_ctl(exp_st));
      check(pc_en == (model_ctl(exp_st)[15] | (model_ctl(exp_st)[14] & alu_zero)), "R11",
            pc_en, model_ctl(exp_st)[15] | (model_ctl(exp_st)[14] & alu_zero));
      if (phase == 4'd0) begin
        check(run_len == model_len(opcode), (model_len(opcode) == 2) ? "R12" : "R10",
              run_len, model_len(opcode));
        run_len = 1;
      end else begin
        run_len++;
      end
      alu_zero = 1'($urandom);
      if (exp_st == 4'd0) begin
        opcode = pick_op(instr);
        instr++;
      end
      exp_st = model_next(exp_st, opcode);
      if (exp_st == 4'd8) begin
        // hold opcode steady; zero toggles within branch cycle checked next
      end
    end
    // directed mid-run reset from a store's memory phase
    opcode = 6'b101011;
    while (phase != 4'd5) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(phase == 4'd0 && !mem_wr, "R1", phase, 0);
    rst = 1'b0;
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule